// File: doc/BRIEF.md
# Transceiver Operating Mode Sequencer

This block tracks which of five operating modes a packet transceiver is in: power-down, the two standby modes, receive and transmit. Each clock it looks at the power-enable bit, the receive-select bit, the chip-enable level and whether the transmit queue is empty. Timed delays are enforced by a cycle counter whose limits come from the clock rate in MHz. Wake-up from power-down takes 1.5 ms. Moving from either standby mode into an active mode takes a 130 µs settle time. A transmit start requested by a short chip-enable pulse needs at least 10 µs of high level.

The sequencer also holds three sticky event flags: packet received, packet sent and retries exhausted. Each flag is cleared on its own by writing 1 to its bit. A single active-low interrupt line is asserted while any flag is set. The surrounding radio logic supplies the event pulses and reads back the mode and the settle status.

Top module: `radio_mode_ctrl`

## Requirements
- R1: During and after reset, `mode_o` is 0 and `settling_o`, `irq_flags_o` and `irq_no` are 0, 0 and 1. The mode codes are 0 power-down, 1 standby-I, 2 standby-II, 3 receive and 4 transmit.
- R2: When `pwr_up_i` is sampled low, `mode_o` becomes 0 at that clock edge from any mode, and the interrupt flags keep their values.
- R3: After `pwr_up_i` is first sampled high in power-down, `mode_o` stays 0 with `settling_o` high for CLK_MHZ*PWRUP_US clocks, and then becomes 1.
- R4: In standby, chip-enable low selects standby-I. Chip-enable high with `prim_rx_i` low and the transmit queue empty selects standby-II.
- R5: From either standby, chip-enable high with `prim_rx_i` high (receive), or with `prim_rx_i` low and a non-empty queue (transmit), starts a settle. During the settle `settling_o` is high and `mode_o` keeps the standby code for CLK_MHZ*SETTLE_US clocks; the active mode is entered on the next clock.
- R6: If chip-enable falls during a transmit settle before it has been sampled high on CLK_MHZ*CE_MIN_US consecutive clocks, the block returns to standby-I. Once that count is reached, the transmit proceeds even with chip-enable low.
- R7: Receive mode returns to standby-I on the clock after chip-enable (or `prim_rx_i`) is sampled low.
- R8: Transmit mode is held regardless of chip-enable until `tx_done_i` or `max_rt_i` is sampled high. It then goes to standby-I if chip-enable is low and to standby-II if it is high.
- R9: `irq_flags_o` bit 0 is set by `rx_pkt_i` in receive or transmit mode. Bit 1 is set by `tx_done_i` in transmit mode, and bit 2 by `max_rt_i` in transmit mode. Events in other modes are ignored. When `tx_done_i` and `max_rt_i` arrive together, only bit 2 is set. Bits 0 and 1 can be set in the same clock.
- R10: A 1 in a bit of `flag_clr_i` clears that flag at the next clock. An event setting the same flag in that clock takes precedence.
- R11: `irq_no` is low exactly while any bit of `irq_flags_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_up_i | input | 1 | Power enable bit |
| prim_rx_i | input | 1 | 1 selects receive role, 0 transmit role |
| ce_i | input | 1 | Chip-enable level |
| txq_empty_i | input | 1 | Transmit queue empty |
| rx_pkt_i | input | 1 | Packet received event pulse |
| tx_done_i | input | 1 | Packet sent event pulse |
| max_rt_i | input | 1 | Retries exhausted event pulse |
| flag_clr_i | input | 3 | Write-1-to-clear strobes for the flags |
| mode_o | output | 3 | Current mode code |
| settling_o | output | 1 | Wake-up or settle delay running |
| irq_flags_o | output | 3 | Sticky flags: bit0 rx, bit1 tx done, bit2 retries exhausted |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
The bench aims at the chip-enable pulse threshold, driving pulses one clock short of the minimum and exactly at it. A sequencer that counted one cycle off would either start a transmit on a pulse that is too short or drop a valid one. It also drops chip-enable during transmit and during receive: a design that treated the two alike would either cut off the packet in flight or stay in receive. It presents done and retry-exhausted together, a clear strobe together with a new event, and events outside the active modes, so a wrong priority shows up as a flag that is missing or one set by mistake. It also counts the exact wake and settle clocks to catch off-by-one timers, and checks that the flags survive a drop into power-down.

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl #(
  parameter int CLK_MHZ   = 4,
  parameter int PWRUP_US  = 1500,
  parameter int SETTLE_US = 130,
  parameter int CE_MIN_US = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_up_i,
  input  logic       prim_rx_i,
  input  logic       ce_i,
  input  logic       txq_empty_i,
  input  logic       rx_pkt_i,
  input  logic       tx_done_i,
  input  logic       max_rt_i,
  input  logic [2:0] flag_clr_i,
  output logic [2:0] mode_o,
  output logic       settling_o,
  output logic [2:0] irq_flags_o,
  output logic       irq_no
);
  localparam int WAKE_CYC   = CLK_MHZ * PWRUP_US;
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int CE_CYC     = CLK_MHZ * CE_MIN_US;
  localparam int MAX_CYC    = (WAKE_CYC > SETTLE_CYC) ? WAKE_CYC : SETTLE_CYC;
  localparam int CW         = $clog2(MAX_CYC) + 1;
  localparam int HW         = $clog2(CE_CYC + 1) + 1;

  typedef enum logic [2:0] {S_PD, S_WAKE, S_SB1, S_SB2, S_SETTLE, S_RX, S_TX} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hi_cnt;
  logic          to_tx, from_sb2;
  logic [2:0]    set_f;

  wire armed = (hi_cnt >= HW'(CE_CYC));
  wire in_tx = (st == S_TX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= S_PD;
      cnt      <= '0;
      hi_cnt   <= '0;
      to_tx    <= 1'b0;
      from_sb2 <= 1'b0;
    end else if (!pwr_up_i) begin
      st  <= S_PD;
      cnt <= '0;
    end else begin
      case (st)
        S_PD: begin
          st  <= S_WAKE;
          cnt <= '0;
        end
        S_WAKE:
          if (cnt == CW'(WAKE_CYC - 1)) st <= S_SB1;
          else cnt <= cnt + 1'b1;
        S_SB1, S_SB2:
          if (!ce_i) st <= S_SB1;
          else if (prim_rx_i || !txq_empty_i) begin
            st       <= S_SETTLE;
            cnt      <= '0;
            hi_cnt   <= HW'(1);
            to_tx    <= !prim_rx_i;
            from_sb2 <= (st == S_SB2);
          end else st <= S_SB2;
        S_SETTLE: begin
          if (ce_i && !armed) hi_cnt <= hi_cnt + 1'b1;
          if (!to_tx && (!ce_i || !prim_rx_i)) st <= S_SB1;
          else if (to_tx && !ce_i && !armed) st <= S_SB1;
          else if (cnt == CW'(SETTLE_CYC - 1)) st <= to_tx ? S_TX : S_RX;
          else cnt <= cnt + 1'b1;
        end
        S_RX:
          if (!ce_i || !prim_rx_i) st <= S_SB1;
        S_TX:
          if (tx_done_i || max_rt_i) st <= ce_i ? S_SB2 : S_SB1;
        default: st <= S_PD;
      endcase
    end
  end

  assign set_f[0] = rx_pkt_i && (in_tx || st == S_RX);
  assign set_f[1] = in_tx && tx_done_i && !max_rt_i;
  assign set_f[2] = in_tx && max_rt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_flags_o <= '0;
    else         irq_flags_o <= set_f | (irq_flags_o & ~flag_clr_i);
  end

  assign irq_no     = ~|irq_flags_o;
  assign settling_o = (st == S_WAKE) || (st == S_SETTLE);

  always_comb begin
    case (st)
      S_SB1:    mode_o = 3'd1;
      S_SB2:    mode_o = 3'd2;
      S_SETTLE: mode_o = from_sb2 ? 3'd2 : 3'd1;
      S_RX:     mode_o = 3'd3;
      S_TX:     mode_o = 3'd4;
      default:  mode_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/radio_mode_ctrl_chk.sv
module radio_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_up_i,
  input logic       ce_i,
  input logic       tx_done_i,
  input logic       max_rt_i,
  input logic [2:0] flag_clr_i,
  input logic [2:0] mode_o,
  input logic       settling_o,
  input logic [2:0] irq_flags_o
);
  // R2
  pd_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_up_i |=> mode_o == 3'd0);

  // R5
  active_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'd3 && mode_o != 3'd4) |=> ((mode_o != 3'd3 && mode_o != 3'd4) || $past(settling_o)));

  // R7
  rx_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_up_i && mode_o == 3'd3 && !ce_i) |=> mode_o == 3'd1);

  // R8
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_up_i && mode_o == 3'd4 && !tx_done_i && !max_rt_i) |=> mode_o == 3'd4);

  // R9
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(irq_flags_o[1]) && $rose(irq_flags_o[2])));

  // R10
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i[1] && !tx_done_i) |=> !irq_flags_o[1]);
endmodule

bind radio_mode_ctrl radio_mode_ctrl_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_up_i(pwr_up_i), .ce_i(ce_i),
  .tx_done_i(tx_done_i), .max_rt_i(max_rt_i), .flag_clr_i(flag_clr_i),
  .mode_o(mode_o), .settling_o(settling_o), .irq_flags_o(irq_flags_o)
);

// File: tb/radio_mode_ctrl_tb_top.sv
module radio_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE   = 1500;
  localparam int SETTLE = 130;
  localparam int CEMIN  = 10;

  // {prim_rx, ce, txq_empty, expected mode}
  localparam logic [5:0] VECS [0:7] = '{
    6'b001_001, 6'b111_011, 6'b101_001, 6'b011_010,
    6'b111_011, 6'b011_010, 6'b010_100, 6'b000_100
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_up = 0, prim_rx = 0, ce = 0, empty = 1;
  logic rx_pkt = 0, tx_done = 0, max_rt = 0;
  logic [2:0] clr = '0;
  logic [2:0] mode, flags;
  logic settling, irq_n;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_mode_ctrl #(.CLK_MHZ(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_up_i(pwr_up), .prim_rx_i(prim_rx),
    .ce_i(ce), .txq_empty_i(empty), .rx_pkt_i(rx_pkt), .tx_done_i(tx_done),
    .max_rt_i(max_rt), .flag_clr_i(clr), .mode_o(mode), .settling_o(settling),
    .irq_flags_o(flags), .irq_no(irq_n)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R1 mode", mode, 0); chk("R1 settling", settling, 0);
    chk("R1 flags", flags, 0); chk("R1 irq_n", irq_n, 1);
    rst_n = 1'b1;
    tick(5);
    chk("R2 stays down", mode, 0);
    pwr_up = 1'b1;
    tick(WAKE);
    chk("R3 wake mode", mode, 0); chk("R3 wake settling", settling, 1);
    tick(1);
    chk("R3 standby", mode, 1); chk("R3 settle done", settling, 0);

    for (int i = 0; i < 8; i++) begin
      {prim_rx, ce, empty} = VECS[i][5:3];
      tick(200);
      chk("R4 R5 R7 R8 table", mode, {29'd0, VECS[i][2:0]});
    end

    tx_done = 1; tick(1); tx_done = 0;
    chk("R8 done to SB1", mode, 1); chk("R9 tx flag", flags, 3'b010);
    chk("R11 irq low", irq_n, 0);
    clr = 3'b010; tick(1); clr = 0;
    chk("R10 clear", flags, 0); chk("R11 irq high", irq_n, 1);

    rx_pkt = 1; tx_done = 1; max_rt = 1; tick(1);
    rx_pkt = 0; tx_done = 0; max_rt = 0;
    chk("R9 ignored in standby", flags, 0);

    prim_rx = 1; ce = 1; tick(SETTLE);
    chk("R5 settle mode", mode, 1); chk("R5 settle busy", settling, 1);
    tick(1);
    chk("R5 rx entered", mode, 3); chk("R5 settle over", settling, 0);
    rx_pkt = 1; tick(1); rx_pkt = 0;
    chk("R9 rx flag", flags, 3'b001);
    rx_pkt = 1; clr = 3'b001; tick(1); rx_pkt = 0; clr = 0;
    chk("R10 set wins", flags, 3'b001);
    clr = 3'b001; tick(1); clr = 0;
    chk("R10 rx clear", flags, 0);
    ce = 0; tick(1);
    chk("R7 rx exit", mode, 1);

    prim_rx = 0; empty = 0; ce = 1; tick(CEMIN - 1); ce = 0; tick(1);
    chk("R6 short pulse mode", mode, 1); chk("R6 short pulse settling", settling, 0);
    tick(SETTLE + 5);
    chk("R6 short pulse no tx", mode, 1);

    ce = 1; tick(CEMIN); ce = 0; tick(1);
    chk("R6 long pulse settling", settling, 1);
    tick(SETTLE);
    chk("R6 long pulse tx", mode, 4);

    tx_done = 1; max_rt = 1; tick(1); tx_done = 0; max_rt = 0;
    chk("R9 rt wins", flags, 3'b100); chk("R8 rt to SB1", mode, 1);
    chk("R11 irq rt", irq_n, 0);
    clr = 3'b100; tick(1); clr = 0;
    chk("R10 rt clear", flags, 0);

    ce = 1; tick(200);
    chk("R5 tx again", mode, 4);
    rx_pkt = 1; tx_done = 1; empty = 1; tick(1); rx_pkt = 0; tx_done = 0;
    chk("R9 rx and tx together", flags, 3'b011); chk("R8 done to SB2", mode, 2);

    pwr_up = 0; tick(1);
    chk("R2 power down", mode, 0); chk("R2 flags kept", flags, 3'b011);
    max_rt = 1; tick(1); max_rt = 0;
    chk("R9 ignored in power-down", flags, 3'b011);
    clr = 3'b111; tick(1); clr = 0;
    chk("R10 clear all", flags, 0); chk("R11 irq released", irq_n, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule